// File: doc/BRIEF.md
# Supply-Loss Guard and Backup Source Controller

This block supervises the supply of a battery-backed static memory. Four comparator flags arrive from analogue circuits outside the block, each high while the supply sits above one threshold. From the highest threshold to the lowest these are: the level for full operation, the level by which writes must be blocked, the level at which the memory moves over to the battery, and a separate first-connection level. Each flag is synchronised and debounced. A small state machine then decides whether the memory may be accessed, whether its data outputs must float, and which source powers the array.

The battery path leaves the factory disconnected. It is armed the first time the first-connection flag is seen high, and it stays armed from then on. Until it is armed the block never selects the battery, even when the supply collapses. The control strobes from the host pass through a gate. When protection rises, that gate cuts off any access in progress within the same clock. Return to full operation needs the highest flag again, so the lower flags do not make the block toggle as the supply moves between thresholds.

Top module: `pwr_guard_ctrl`

## Requirements
- R1: Out of reset the block is in its sealed state: `write_protect`=1, `data_hiz`=1, `batt_select`=0, `batt_enabled`=0, and all three gated strobes are 0 whatever the request inputs are.
- R2: Once the battery path is armed and the operate, protect and switchover flags are all high after filtering, the block runs normally: `write_protect`=0, `data_hiz`=0, and each gated strobe equals its request.
- R3: `write_protect` and `data_hiz` go to 1 in the same clock cycle in which the filtered operate flag is first seen low.
- R4: After a fall below the operate level, the block stays protected on the supply (`batt_select`=0) while the switchover flag is high. It stays protected when only the protect flag returns. It resumes normal operation only when the operate flag is high again.
- R5: With the battery path armed, a filtered switchover flag low sets `batt_select`=1 and keeps the block protected.
- R6: When the switchover flag returns high, `batt_select` goes back to 0 and the block stays protected until R4 allows operation.
- R7: `batt_enabled` goes to 1 the first time the filtered first-connection flag is high, and it stays 1 after that flag falls, until reset.
- R8: While `batt_enabled`=0 the block never sets `batt_select`, and it stays protected even when the other three flags are high.
- R9: A raw flag change that lasts fewer than `DEB_CYCLES` synchronised cycles has no effect on any output.
- R10: An access strobe held high when protection asserts is forced to 0 at the gated output in that same cycle.
- R11: A low filtered protect flag forces `write_protect`=1, even while the operate flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| above_run_raw | input | 1 | Supply above the full-operation level (asynchronous) |
| above_wp_raw | input | 1 | Supply above the write-block level (asynchronous) |
| above_swap_raw | input | 1 | Supply above the battery switchover level (asynchronous) |
| above_seal_raw | input | 1 | Supply above the first-connection level (asynchronous) |
| sel_req | input | 1 | Host chip-select strobe, active high |
| wr_req | input | 1 | Host write strobe, active high |
| rd_req | input | 1 | Host output-enable strobe, active high |
| sel_gated | output | 1 | Chip-select to the array, blocked while protected |
| wr_gated | output | 1 | Write strobe to the array, blocked while protected |
| rd_gated | output | 1 | Output-enable to the array, blocked while protected |
| write_protect | output | 1 | 1 while writes are blocked |
| data_hiz | output | 1 | 1 while the data outputs must float |
| batt_select | output | 1 | 1 selects the battery as array source, 0 the supply |
| batt_enabled | output | 1 | Latched arming of the battery path |

## Verification
The hardest case to reach is a write strobe that is already high when protection asserts, because the cut-off must land in exactly the cycle in which the filtered flag falls. The bench holds the write request high and lowers only the operate flag. It then steps edge by edge until `write_protect` rises, and at that same sample it checks that the gated write is low. The sealed path is also hard to reach: it needs a supply collapse before any first-connection event. The bench drives all the other flags high and then drops switchover with the first-connection flag still low.

// File: rtl/pwr_guard_pkg.sv
// Shared definitions for the supply-loss guard.
// Assumes flag vectors are indexed with the constants below.
package pwr_guard_pkg;

    // Supervisor states
    typedef enum logic [1:0] {
        ST_SEALED    = 2'd0,
        ST_PROTECTED = 2'd1,
        ST_NORMAL    = 2'd2,
        ST_BATTERY   = 2'd3
    } guard_state_t;

    // Positions of the comparator flags in the packed flag vector
    localparam int FLAG_RUN  = 0;
    localparam int FLAG_WP   = 1;
    localparam int FLAG_SWAP = 2;
    localparam int FLAG_SEAL = 3;
    localparam int NUM_FLAGS = 4;

    // Positions of the host strobes in the packed strobe vector
    localparam int STB_SEL = 0;
    localparam int STB_WR  = 1;
    localparam int STB_RD  = 2;
    localparam int NUM_STB = 3;

endpackage

// File: rtl/flag_filter.sv
// Two-flop synchroniser followed by a debounce counter for one flag.
// The filtered value follows the synchronised value only after it has
// disagreed for DEB_CYCLES consecutive clocks. Assumes DEB_CYCLES >= 2.
// Filtered output resets low (supply treated as absent).
module flag_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] cnt_q;
    logic          filt_q;

    // Bring the asynchronous flag into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    // Count consecutive disagreement and commit after DEB_CYCLES
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (sync_q == filt_q) begin
            cnt_q  <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            filt_q <= sync_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;

    // R9
    deb_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(cnt_q) == CNT_LAST));

endmodule

// File: rtl/flag_conditioner.sv
// Conditions every comparator flag with its own synchroniser and debounce
// filter. Assumes all flags share one debounce length.
module flag_conditioner #(
    parameter int N_FLAGS    = 4,
    parameter int DEB_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] raw_i,
    output logic [N_FLAGS-1:0] filt_o
);
    // One filter per flag
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        flag_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_i[g]),
            .filt_o (filt_o[g])
        );
    end
endmodule

// File: rtl/seal_latch.sv
// One-time arming of the battery path. Set by the first filtered
// first-connection flag, cleared only by reset.
module seal_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic seal_flag_i,
    output logic armed_o
);
    logic armed_q;

    // Sticky set on the first-connection event
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_q | seal_flag_i;
    end

    assign armed_o = armed_q;

    // R7
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q);

endmodule

// File: rtl/guard_fsm.sv
// Supervisor state machine. Moves between sealed, protected, normal and
// battery states from the filtered flags. Protection is combinational on
// the registered state and the filtered flags, so it rises in the cycle
// the fall is seen. Assumes flags are already synchronised.
module guard_fsm
    import pwr_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_ok_i,
    input  logic wp_ok_i,
    input  logic swap_ok_i,
    input  logic armed_i,
    output logic protect_o,
    output logic batt_sel_o
);
    guard_state_t state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEALED: begin
                if (armed_i) state_d = ST_PROTECTED;
            end
            ST_PROTECTED: begin
                if (!swap_ok_i && armed_i)
                    state_d = ST_BATTERY;
                else if (run_ok_i && wp_ok_i && swap_ok_i)
                    state_d = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (!swap_ok_i && armed_i)
                    state_d = ST_BATTERY;
                else if (!run_ok_i || !wp_ok_i || !swap_ok_i)
                    state_d = ST_PROTECTED;
            end
            ST_BATTERY: begin
                if (swap_ok_i) state_d = ST_PROTECTED;
            end
            default: state_d = ST_SEALED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEALED;
        else        state_q <= state_d;
    end

    // Protection: any non-normal state, or a flag already low this cycle
    assign protect_o  = (state_q != ST_NORMAL) | ~run_ok_i | ~wp_ok_i;
    assign batt_sel_o = (state_q == ST_BATTERY);

    // R8
    no_batt_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |-> (state_q != ST_BATTERY));

    // R5
    batt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && !swap_ok_i && state_q != ST_SEALED) |=> (state_q == ST_BATTERY));

    // R4
    normal_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NORMAL) ##1 (state_q == ST_NORMAL) |-> $past(run_ok_i));

endmodule

// File: rtl/strobe_gate.sv
// Blocks the host access strobes while protection is active. Purely
// combinational so an access in flight is cut off in the same cycle.
module strobe_gate #(
    parameter int N_STB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             block_i,
    input  logic [N_STB-1:0] req_i,
    output logic [N_STB-1:0] gated_o
);
    // Per-strobe AND with the inverted block
    for (genvar g = 0; g < N_STB; g++) begin : g_stb
        assign gated_o[g] = req_i[g] & ~block_i;
    end

    // R10
    cut_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |-> (gated_o == '0));

endmodule

// File: rtl/pwr_guard_ctrl.sv
// Top of the supply-loss guard. Filters the four comparator flags, keeps
// the one-time battery arming, sequences the supervisor states and gates
// the host strobes. Assumes flags are ordered run > wp > swap in level.
module pwr_guard_ctrl
    import pwr_guard_pkg::*;
#(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_run_raw,
    input  logic above_wp_raw,
    input  logic above_swap_raw,
    input  logic above_seal_raw,
    input  logic sel_req,
    input  logic wr_req,
    input  logic rd_req,
    output logic sel_gated,
    output logic wr_gated,
    output logic rd_gated,
    output logic write_protect,
    output logic data_hiz,
    output logic batt_select,
    output logic batt_enabled
);
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] ok_flags;
    logic [NUM_STB-1:0]   req_vec;
    logic [NUM_STB-1:0]   gated_vec;
    logic                 armed;
    logic                 protect;
    logic                 batt_sel;

    // Pack the asynchronous flags
    always_comb begin
        raw_flags            = '0;
        raw_flags[FLAG_RUN]  = above_run_raw;
        raw_flags[FLAG_WP]   = above_wp_raw;
        raw_flags[FLAG_SWAP] = above_swap_raw;
        raw_flags[FLAG_SEAL] = above_seal_raw;
    end

    flag_conditioner #(.N_FLAGS(NUM_FLAGS), .DEB_CYCLES(DEB_CYCLES)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_flags),
        .filt_o (ok_flags)
    );

    seal_latch u_seal (
        .clk         (clk),
        .rst_n       (rst_n),
        .seal_flag_i (ok_flags[FLAG_SEAL]),
        .armed_o     (armed)
    );

    guard_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_ok_i   (ok_flags[FLAG_RUN]),
        .wp_ok_i    (ok_flags[FLAG_WP]),
        .swap_ok_i  (ok_flags[FLAG_SWAP]),
        .armed_i    (armed),
        .protect_o  (protect),
        .batt_sel_o (batt_sel)
    );

    // Pack the host strobes
    always_comb begin
        req_vec          = '0;
        req_vec[STB_SEL] = sel_req;
        req_vec[STB_WR]  = wr_req;
        req_vec[STB_RD]  = rd_req;
    end

    strobe_gate #(.N_STB(NUM_STB)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .block_i (protect),
        .req_i   (req_vec),
        .gated_o (gated_vec)
    );

    assign sel_gated     = gated_vec[STB_SEL];
    assign wr_gated      = gated_vec[STB_WR];
    assign rd_gated      = gated_vec[STB_RD];
    assign write_protect = protect;
    assign data_hiz      = protect;
    assign batt_select   = batt_sel;
    assign batt_enabled  = armed;

    // R3
    run_low_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_flags[FLAG_RUN] |-> (write_protect && data_hiz));

    // R11
    wp_low_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_flags[FLAG_WP] |-> write_protect);

    // R6
    batt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_select && ok_flags[FLAG_SWAP]) |=> (!batt_select && write_protect));

endmodule

// File: tb/tb_pwr_guard_ctrl.sv
module tb_pwr_guard_ctrl;
    localparam int DEB = 6;
    localparam int SETTLE = DEB + 8;

    typedef struct {
        logic       wp;
        logic       hiz;
        logic       bsel;
        logic       armed;
        logic [2:0] stb;   // {rd, wr, sel}
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_run = 0, f_wp = 0, f_swap = 0, f_seal = 0;
    logic q_sel = 0, q_wr = 0, q_rd = 0;
    logic g_sel, g_wr, g_rd, wprot, hiz, bsel, armed;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    pwr_guard_ctrl #(.DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n),
        .above_run_raw(f_run), .above_wp_raw(f_wp),
        .above_swap_raw(f_swap), .above_seal_raw(f_seal),
        .sel_req(q_sel), .wr_req(q_wr), .rd_req(q_rd),
        .sel_gated(g_sel), .wr_gated(g_wr), .rd_gated(g_rd),
        .write_protect(wprot), .data_hiz(hiz),
        .batt_select(bsel), .batt_enabled(armed)
    );

    task automatic report(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                logic [6:0] a, x;
                e = sb.pop_front();
                a = {wprot, hiz, bsel, armed, g_rd, g_wr, g_sel};
                x = {e.wp, e.hiz, e.bsel, e.armed, e.stb};
                report(a === x, e.tag, $sformatf("%b", a), $sformatf("%b", x));
            end
        end
    end

    // Driver: set flags and strobes, let them settle, queue the expectation
    task automatic drive(input logic [3:0] fl, input logic [2:0] st,
                         input logic wp, input logic hz, input logic bs,
                         input logic ar, input logic [2:0] es, input string tag);
        exp_t e;
        @(negedge clk);
        {f_seal, f_swap, f_wp, f_run} = fl;
        {q_rd, q_wr, q_sel} = st;
        repeat (SETTLE) @(negedge clk);
        e.wp = wp; e.hiz = hz; e.bsel = bs; e.armed = ar; e.stb = es; e.tag = tag;
        sb.push_back(e);
        while (sb.size() > 0) @(posedge clk);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        // flag vector order: {seal, swap, wp, run}; strobes {rd, wr, sel}
        q_sel = 1; q_wr = 1; q_rd = 1;
        repeat (5) @(negedge clk);
        report(wprot === 1 && hiz === 1 && bsel === 0 && armed === 0 &&
               {g_rd, g_wr, g_sel} === 3'b000, "R1 reset state",
               $sformatf("%b%b%b%b%b%b%b", wprot, hiz, bsel, armed, g_rd, g_wr, g_sel), "1100000");
        rst_n = 1;

        // Sealed: everything up except first-connection
        drive(4'b0111, 3'b111, 1, 1, 0, 0, 3'b000, "R8 sealed stays protected");
        drive(4'b0011, 3'b111, 1, 1, 0, 0, 3'b000, "R8 no battery while sealed");

        // First connection, normal operation with two strobe patterns
        drive(4'b1111, 3'b101, 0, 0, 0, 1, 3'b101, "R2 normal after arming pattern 101");
        drive(4'b1111, 3'b010, 0, 0, 0, 1, 3'b010, "R2 normal pattern 010");

        // Short glitch on the operate flag is ignored
        @(negedge clk);
        f_run = 0;
        repeat (3) @(negedge clk);
        f_run = 1;
        begin
            bit hit = 0;
            for (int i = 0; i < SETTLE; i++) begin
                @(negedge clk);
                if (wprot !== 0 || g_wr !== 1) hit = 1;
            end
            report(!hit, "R9 glitch ignored", $sformatf("%b", hit), "0");
        end

        // Protect flag low alone forces protection
        drive(4'b1101, 3'b010, 1, 1, 0, 1, 3'b000, "R11 protect flag forces protection");
        drive(4'b1111, 3'b010, 0, 0, 0, 1, 3'b010, "R2 restored");

        // First-connection flag falls, arming stays
        drive(4'b0111, 3'b010, 0, 0, 0, 1, 3'b010, "R7 arming sticky");

        // Write in flight, operate flag drops: same-cycle cut-off
        @(negedge clk);
        f_run = 0;
        begin
            bit seen = 0;
            for (int i = 0; i < SETTLE + 4 && !seen; i++) begin
                @(negedge clk);
                if (wprot === 1) begin
                    seen = 1;
                    report(g_wr === 0 && hiz === 1, "R10 R3 write cut same cycle",
                           $sformatf("wr=%b hiz=%b", g_wr, hiz), "wr=0 hiz=1");
                end else begin
                    report(g_wr === 1, "R10 write passes before protection",
                           $sformatf("%b", g_wr), "1");
                end
            end
            report(seen, "R3 protection rose", $sformatf("%b", seen), "1");
        end
        drive(4'b0110, 3'b010, 1, 1, 0, 1, 3'b000, "R4 protected on supply");
        drive(4'b0100, 3'b010, 1, 1, 0, 1, 3'b000, "R4 below protect still on supply");

        // Battery switchover and return
        drive(4'b0000, 3'b111, 1, 1, 1, 1, 3'b000, "R5 battery selected");
        drive(4'b0100, 3'b111, 1, 1, 0, 1, 3'b000, "R6 supply reselected");
        drive(4'b0110, 3'b111, 1, 1, 0, 1, 3'b000, "R4 hysteresis without operate flag");
        drive(4'b0111, 3'b111, 0, 0, 0, 1, 3'b111, "R4 R2 resume normal");

        // Direct collapse from normal
        drive(4'b0000, 3'b111, 1, 1, 1, 1, 3'b000, "R5 collapse from normal");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule